// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block generates four independent pulse-width-modulated outputs under control of a simple 32-bit register port. A write takes effect on the clock edge where the write strobe is high. A read returns its data on the clock edge after the read strobe is sampled. The channels are grouped in pairs: channels 0 and 1 share one programmable prescaler, and channels 2 and 3 share a second one. Each prescaler divides the system clock by its field value plus one. A field of zero halts that prescaler, and the two channels it feeds freeze.

Behind its prescaler, each channel has a power-of-two clock selector, a down-counter that is reloaded from a programmable value, and a comparator. A channel's output is active while its counter is at or below the comparator value. Each channel has its own enable, polarity and auto-reload controls. When a channel's counter passes through zero, the channel raises a latched event flag. The flags are combined with a mask to form one interrupt line.

A typical use is fan or LED drive. Software programs the prescaler, clock selection, reload value and comparator value, then sets the channel's enable bit. After that it changes the comparator value to adjust the duty cycle. A new comparator or reload value applies only at the next period boundary, so every output period is whole.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset, every output and `irq` are low, and the control and prescale registers read back as zero.
- R2: The prescale register at offset 0x0 holds two fields: bits [7:0] feed channels 0 and 1, and bits [15:8] feed channels 2 and 3. A channel's period is (reload+1) x (field+1) x divisor system clocks. Reload values are at 0xC+12n.
- R3: The comparator register for channel n is at 0x10+12n. The output is active for (compare+1) counter clocks per period. A compare value at or above the reload value gives an output that is active all the time.
- R4: The inversion bits are bits 2, 10, 14 and 18 of the control register at 0x8. Setting a channel's inversion bit inverts its output. A disabled channel drives its inactive level: 0 when not inverted, 1 when inverted.
- R5: The clock-select register at 0x4 gives each channel the nibble at bits [4n+3:4n]. Code 4 divides the prescaled clock by 1. Codes 0, 1, 2 and 3 divide it by 2, 4, 8 and 16.
- R6: A prescale field of zero freezes the counters and outputs of both channels fed by that field. The other pair of channels keeps running.
- R7: The enable bits are bits 0, 8, 12 and 16 of the control register. The auto-reload bits are bits 3, 11, 15 and 19. With auto-reload set, the channel runs continuously. With auto-reload clear, the channel runs for one period, then clears its own enable bit and goes inactive.
- R8: Each counter underflow sets bit n of the flag register at 0x40. Writing 1 to a flag bit clears it. `irq` is the OR of the flag bits masked by bits [3:0] of the mask register at 0x3C.
- R9: Comparator and reload values written while a channel runs take effect at the next reload. The status register at 0x14+12n reads as: count in bits [7:0], active compare value in bits [15:8], active reload value in bits [23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid after the next edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | Channel outputs |
| irq | output | 1 | Masked event interrupt |

## Verification
A wrong count or a wrong divide state shows up within one period as an output period or high time of the wrong length. The bench measures both, cycle by cycle, between rising edges of the output. A wrong shadow or run state shows in the status register or the control register. This happens either immediately (a compare value applied too early) or after one period (an enable bit that does not clear, or a flag that is not raised). A stuck prescaler or selector shows as a status count that changes while it should hold, or one that holds while it should advance.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  // Position of a channel's control bits inside the control word
  function automatic int unsigned run_bit(int unsigned ch);
    return (ch == 0) ? 0 : (4 + 4 * ch);
  endfunction
  function automatic int unsigned pol_bit(int unsigned ch);
    return run_bit(ch) + 2;
  endfunction
  function automatic int unsigned loop_bit(int unsigned ch);
    return run_bit(ch) + 3;
  endfunction

  // Clock-select nibble to divider mask (code 4 and unused codes: divide by one)
  function automatic logic [3:0] sel_mask(logic [3:0] code);
    case (code)
      4'd0:    return 4'b0001;
      4'd1:    return 4'b0011;
      4'd2:    return 4'b0111;
      4'd3:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  localparam int unsigned OFS_PRE  = 'h00;
  localparam int unsigned OFS_SEL  = 'h04;
  localparam int unsigned OFS_CTL  = 'h08;
  localparam int unsigned OFS_CH0  = 'h0C;
  localparam int unsigned CH_STEP  = 12;
  localparam int unsigned OFS_MASK = 'h3C;
  localparam int unsigned OFS_FLAG = 'h40;
endpackage

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_nx;
  logic             wrap;

  always_comb begin
    wrap    = (pcnt_q >= div);
    pcnt_nx = wrap ? '0 : pcnt_q + 1'b1;
    tick    = (div != '0) && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_nx;
  end

  // R2
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
  import pwm4_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic             en,
  input  logic             inv,
  input  logic             auto_rl,
  input  logic [3:0]       sel,
  input  logic [CNT_W-1:0] reload_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic             out,
  output logic             uf,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] rl_act
);
  logic             run_q, run_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CNT_W-1:0] cmp_q, cmp_nx, rl_q, rl_nx;
  logic [3:0]       dcnt_q, dcnt_nx, dmask;
  logic             load, ch_tick, at_zero, refill;

  always_comb begin
    dmask   = sel_mask(sel);
    load    = en && !run_q;
    ch_tick = pre_tick && run_q && ((dcnt_q & dmask) == dmask);
    at_zero = (cnt_q == '0);
    uf      = ch_tick && at_zero;
    done    = uf && !auto_rl;
    refill  = load || (uf && auto_rl);

    run_nx = run_q;
    if (!en)       run_nx = 1'b0;
    else if (load) run_nx = 1'b1;
    else if (done) run_nx = 1'b0;

    cnt_nx = cnt_q;
    if (load)                 cnt_nx = reload_in;
    else if (ch_tick)         cnt_nx = at_zero ? (auto_rl ? reload_in : cnt_q) : cnt_q - 1'b1;

    cmp_nx = refill ? cmp_in    : cmp_q;
    rl_nx  = refill ? reload_in : rl_q;

    dcnt_nx = dcnt_q;
    if (!run_q)        dcnt_nx = '0;
    else if (pre_tick) dcnt_nx = dcnt_q + 1'b1;

    out     = (en && run_q && (cnt_q <= cmp_q)) ^ inv;
    count   = cnt_q;
    cmp_act = cmp_q;
    rl_act  = rl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '0;
      rl_q   <= '0;
      dcnt_q <= '0;
    end else begin
      run_q  <= run_nx;
      cnt_q  <= cnt_nx;
      cmp_q  <= cmp_nx;
      rl_q   <= rl_nx;
      dcnt_q <= dcnt_nx;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ch_tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !pre_tick) |=> $stable(cnt_q));
  // R9
  shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !uf) |=> ($stable(cmp_q) && $stable(rl_q)));
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int CNT_W = 8,
  parameter int PRE_W = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [N_CH-1:0] pwm_out,
  output logic          irq
);
  localparam int N_PRE = N_CH / 2;
  localparam int PRE_BITS = N_PRE * PRE_W;
  localparam int SEL_BITS = 4 * N_CH;
  localparam int PAD_W = DW - 3 * CNT_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  logic [PRE_BITS-1:0] pre_q, pre_nx;
  logic [SEL_BITS-1:0] sel_q, sel_nx;
  logic [DW-1:0]       ctl_q, ctl_nx;
  logic [CNT_W-1:0]    rl_q [N_CH], rl_nx [N_CH];
  logic [CNT_W-1:0]    cmp_q[N_CH], cmp_nx[N_CH];
  logic [N_CH-1:0]     mask_q, mask_nx, flag_q, flag_nx;
  logic [DW-1:0]       rd_q, rd_nx;

  logic [N_PRE-1:0]    pre_tick;
  logic [N_CH-1:0]     uf_v, done_v, en_v;
  logic [CNT_W-1:0]    cnt_v[N_CH], cmpa_v[N_CH], rla_v[N_CH];

  genvar gp;
  generate
    for (gp = 0; gp < N_PRE; gp++) begin : g_pre
      pwm4_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rs_q),
        .div  (pre_q[gp*PRE_W +: PRE_W]),
        .tick (pre_tick[gp])
      );
    end
  endgenerate

  genvar gc;
  generate
    for (gc = 0; gc < N_CH; gc++) begin : g_ch
      assign en_v[gc] = ctl_q[run_bit(gc)];
      pwm4_channel #(.CNT_W(CNT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rs_q),
        .pre_tick (pre_tick[gc/2]),
        .en       (ctl_q[run_bit(gc)]),
        .inv      (ctl_q[pol_bit(gc)]),
        .auto_rl  (ctl_q[loop_bit(gc)]),
        .sel      (sel_q[4*gc +: 4]),
        .reload_in(rl_q[gc]),
        .cmp_in   (cmp_q[gc]),
        .out      (pwm_out[gc]),
        .uf       (uf_v[gc]),
        .done     (done_v[gc]),
        .count    (cnt_v[gc]),
        .cmp_act  (cmpa_v[gc]),
        .rl_act   (rla_v[gc])
      );
    end
  endgenerate

  // Register next-state
  always_comb begin
    pre_nx  = pre_q;
    sel_nx  = sel_q;
    ctl_nx  = ctl_q;
    mask_nx = mask_q;
    flag_nx = flag_q;
    for (int i = 0; i < N_CH; i++) begin
      rl_nx[i]  = rl_q[i];
      cmp_nx[i] = cmp_q[i];
    end
    if (bus_wr) begin
      if (bus_addr == AW'(OFS_PRE))  pre_nx  = bus_wdata[PRE_BITS-1:0];
      if (bus_addr == AW'(OFS_SEL))  sel_nx  = bus_wdata[SEL_BITS-1:0];
      if (bus_addr == AW'(OFS_CTL))  ctl_nx  = bus_wdata;
      if (bus_addr == AW'(OFS_MASK)) mask_nx = bus_wdata[N_CH-1:0];
      if (bus_addr == AW'(OFS_FLAG)) flag_nx = flag_q & ~bus_wdata[N_CH-1:0];
      for (int i = 0; i < N_CH; i++) begin
        if (bus_addr == AW'(OFS_CH0 + CH_STEP * i))     rl_nx[i]  = bus_wdata[CNT_W-1:0];
        if (bus_addr == AW'(OFS_CH0 + CH_STEP * i + 4)) cmp_nx[i] = bus_wdata[CNT_W-1:0];
      end
    end
    flag_nx = flag_nx | uf_v;
    for (int i = 0; i < N_CH; i++)
      if (done_v[i]) ctl_nx[run_bit(i)] = 1'b0;
  end

  // Read mux
  always_comb begin
    rd_nx = '0;
    if (bus_addr == AW'(OFS_PRE))  rd_nx = DW'(pre_q);
    if (bus_addr == AW'(OFS_SEL))  rd_nx = DW'(sel_q);
    if (bus_addr == AW'(OFS_CTL))  rd_nx = ctl_q;
    if (bus_addr == AW'(OFS_MASK)) rd_nx = DW'(mask_q);
    if (bus_addr == AW'(OFS_FLAG)) rd_nx = DW'(flag_q);
    for (int i = 0; i < N_CH; i++) begin
      if (bus_addr == AW'(OFS_CH0 + CH_STEP * i))     rd_nx = DW'(rl_q[i]);
      if (bus_addr == AW'(OFS_CH0 + CH_STEP * i + 4)) rd_nx = DW'(cmp_q[i]);
      if (bus_addr == AW'(OFS_CH0 + CH_STEP * i + 8))
        rd_nx = {{PAD_W{1'b0}}, rla_v[i], cmpa_v[i], cnt_v[i]};
    end
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      pre_q  <= '0;
      sel_q  <= '0;
      ctl_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
      rd_q   <= '0;
      for (int i = 0; i < N_CH; i++) begin
        rl_q[i]  <= '0;
        cmp_q[i] <= '0;
      end
    end else begin
      pre_q  <= pre_nx;
      sel_q  <= sel_nx;
      ctl_q  <= ctl_nx;
      mask_q <= mask_nx;
      flag_q <= flag_nx;
      if (bus_rd) rd_q <= rd_nx;
      for (int i = 0; i < N_CH; i++) begin
        rl_q[i]  <= rl_nx[i];
        cmp_q[i] <= cmp_nx[i];
      end
    end
  end

  assign bus_rdata = rd_q;
  assign irq       = |(flag_q & mask_q);

  // R7
  oneshot_clr_chk: assert property (@(posedge clk) disable iff (!rs_q)
    (|done_v) |=> ((en_v & $past(done_v)) == '0));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rs_q)
    (|uf_v) |=> ((flag_q & $past(uf_v)) == $past(uf_v)));
endmodule

// File: tb/sim_pwm4_ctrl.sv
`timescale 1ns/1ps
module sim_pwm4_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  pwm_out;
  logic        irq;

  always #10 clk = ~clk;

  pwm4_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {int hi; int per; string req;} exp_t;
  exp_t q[$];
  int   mon_ch = 0;
  bit   mon_arm = 1'b0;

  function automatic int enb(int ch);  return (ch == 0) ? 0 : 4 + 4 * ch; endfunction
  function automatic int rla(int ch);  return 'hC + 12 * ch; endfunction
  function automatic int cpa(int ch);  return 'h10 + 12 * ch; endfunction
  function automatic int sta(int ch);  return 'h14 + 12 * ch; endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Driver: push expected period/high-time items for one channel
  task automatic expect_wave(int ch, int hi, int per, int n, string req);
    int t = 0;
    mon_ch = ch;
    @(posedge clk); mon_arm = 1'b1;
    @(posedge clk); mon_arm = 1'b0;
    for (int i = 0; i < n; i++) q.push_back('{hi, per, req});
    while (q.size() > 0 && t < 4000) begin @(negedge clk); t++; end
    if (q.size() > 0) begin
      check(req, "periods not seen", q.size(), 0);
      q.delete();
    end
  endtask

  // Monitor: measure rising-edge to rising-edge periods
  initial begin
    bit b, prev = 1'b0, have = 1'b0;
    int pc = 0, hc = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      b = pwm_out[mon_ch];
      if (mon_arm) begin
        have = 1'b0; prev = b;
      end else begin
        if (b && !prev) begin
          if (have && q.size() > 0) begin
            e = q.pop_front();
            check(e.req, "high time", hc, e.hi);
            check(e.req, "period", pc, e.per);
          end
          have = 1'b1; pc = 1; hc = 1;
        end else begin
          pc++;
          if (b) hc++;
        end
        prev = b;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [31:0] ctl;
    logic        o1;
    int          hcnt;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pwm_out in reset", pwm_out, 0);
    check("R1", "irq in reset", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    rd('h8, d); check("R1", "control after reset", d, 0);
    rd('h0, d); check("R1", "prescale after reset", d, 0);

    // Prescale: pair 0/1 divide 2, pair 2/3 divide 3; ch1 selector code 1 (/4)
    wr('h0, 32'h0201);
    wr('h4, 32'h4414);
    wr(rla(0), 7); wr(cpa(0), 3);
    wr(rla(1), 3); wr(cpa(1), 0);
    wr(rla(2), 4); wr(cpa(2), 1);
    wr(rla(3), 3); wr(cpa(3), 0);
    ctl = 0;
    for (int c = 0; c < 4; c++) begin ctl[enb(c)] = 1; ctl[enb(c)+3] = 1; end
    ctl[enb(3)+2] = 1;
    wr('h8, ctl);
    expect_wave(0, 8, 16, 2, "R2");
    expect_wave(1, 8, 32, 2, "R5");
    expect_wave(2, 6, 15, 2, "R3");
    expect_wave(3, 9, 12, 2, "R4");

    // R6: zero the upper prescale field
    wr('h0, 32'h0001);
    repeat (5) @(posedge clk);
    rd(sta(2), d); @(negedge clk); o1 = pwm_out[2];
    repeat (60) @(posedge clk);
    rd(sta(2), d2);
    check("R6", "frozen count", d2[7:0], d[7:0]);
    check("R6", "frozen output", pwm_out[2], o1);
    expect_wave(0, 8, 16, 1, "R6");
    wr('h0, 32'h0201);

    // R3: compare at reload gives constant active
    wr(cpa(2), 4);
    repeat (40) @(posedge clk);
    hcnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_out[2]) hcnt++; end
    check("R3", "full duty samples", hcnt, 30);

    // R4: disabled level follows polarity
    ctl[enb(3)] = 0; ctl[enb(2)] = 0;
    wr('h8, ctl);
    repeat (3) @(posedge clk); @(negedge clk);
    check("R4", "disabled inverted ch3", pwm_out[3], 1);
    check("R4", "disabled plain ch2", pwm_out[2], 0);

    // R7/R8: one-shot and interrupt flags
    wr('h8, 0);
    repeat (3) @(posedge clk);
    wr('h40, 32'hF);
    rd('h40, d); check("R8", "flags cleared", d, 0);
    wr(rla(0), 3); wr(cpa(0), 1);
    wr('h8, 32'h1);
    repeat (60) @(posedge clk);
    rd('h8, d); check("R7", "enable self-cleared", d, 0);
    @(negedge clk); check("R7", "one-shot output idle", pwm_out[0], 0);
    rd('h40, d); check("R8", "flag after underflow", d, 1);
    check("R8", "irq masked", irq, 0);
    wr('h3C, 1);
    @(negedge clk); check("R8", "irq unmasked", irq, 1);
    wr('h40, 1);
    rd('h40, d); check("R8", "flag after clear", d, 0);
    check("R8", "irq after clear", irq, 0);

    // R9: shadowed compare
    wr('h4, 32'h4434);
    wr(rla(1), 100); wr(cpa(1), 10);
    wr('h8, (1 << enb(1)) | (1 << (enb(1)+3)));
    repeat (20) @(posedge clk);
    wr(cpa(1), 50);
    rd(sta(1), d);
    check("R9", "active compare before reload", d[15:8], 10);
    check("R9", "active reload", d[23:16], 100);
    repeat (3500) @(posedge clk);
    rd(sta(1), d);
    check("R9", "active compare after reload", d[15:8], 50);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule